// File: doc/BRIEF.md
# External Interrupt Pending Register

This block keeps the external interrupt pending bits of one processor and decides whether an interrupt is taken. Any agent on the system bus raises an interrupt by posting a word that names a bit. The bit number comes from the inverted low bits of the posted data, in big-endian numbering, so a posted 0 lands in the most significant bit. The register holds 32 bits in narrow mode. It holds 64 bits when the core is built wide-capable and the wide-mode default input is high. A timer alarm raises the same bit as a posted 0.

Software on the processor clears pending bits with a write-one-to-clear port and loads a separate enable mask. The block ORs the pending bits into an interrupt line. It combines the pending bits with the enable mask and the processor's interrupt-enable flag to offer a maskable external cause. A latched non-maskable transfer-of-control request outranks the external cause. It stays offered until the processor acknowledges it.

Top module: `ext_irq_pending`

## Requirements
- R1: After synchronous reset the pending register, the enable mask and the non-maskable request are all 0, so `take_cause` is 0 (none) and `irq_line` is low.
- R2: A bus write of size 4 sets exactly one pending bit one cycle later: register bit `(~bus_wdata) & (W-1)`. W is 64 when `WIDE_CORE`=1 and `wide_dflt`=1, otherwise 32. All other bits keep their values.
- R3: In narrow mode only bits 0..31 can be set and data bits 5 and above do not affect the index, so data 32 sets bit 31.
- R4: A bus access whose `bus_size` is not 4 bytes has no effect: a write changes no pending bit and a read returns 0.
- R5: A bus read of size 4 returns the full 64-bit pending register in the same cycle.
- R6: A local clear removes, one cycle later, every pending bit that is 1 in `clr_mask`.
- R7: When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R8: `irq_line` is high exactly when some pending bit is 1.
- R9: `take_cause` is 1 (external) only when `psw_i` is 1 and pending AND mask is nonzero. The mask is loaded by `mask_wr_en` and is visible one cycle later. Acknowledging an external cause leaves the pending bits unchanged.
- R10: A pulse on `nmi_set` latches a request that makes `take_cause` 2 (transfer of control) from the next cycle, ahead of any external cause. It is cleared by `take_ack` while the cause is 2, and a new `nmi_set` in that same cycle wins.
- R11: `timer_alarm` sets the same bit as a bus write of 0: bit 31 in narrow mode and bit 63 in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_dflt | input | 1 | Wide-mode default bit |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Posted word naming the bit |
| bus_rdata | output | 64 | Pending register on a valid read, else 0 |
| timer_alarm | input | 1 | Timer alarm pulse |
| clr_en | input | 1 | Local clear strobe |
| clr_mask | input | 64 | Bits to clear |
| mask_wr_en | input | 1 | Enable-mask load strobe |
| mask_wdata | input | 64 | New enable mask |
| psw_i | input | 1 | Processor interrupt-enable flag |
| nmi_set | input | 1 | Non-maskable request pulse |
| take_ack | input | 1 | Processor accepts the offered cause |
| irq_line | output | 1 | Any pending bit set |
| take_cause | output | 2 | 0 none, 1 external, 2 transfer of control |

## Verification
Directed posts of 0, 31, 32 and 63 in both modes separate the inverted-index mapping from a plain index, and show that the narrow index ignores data bit 5. Writes with sizes other than 4 bytes, set and clear on the same bit, and a timer alarm in each mode separate the corner rules from the main path. Random mixes of posts, clears, mask loads, enable toggles, non-maskable pulses and acknowledges check the cause priority against a bench model after each cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int MAX_W = 64;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_EXT  = 2'd1,
        CAUSE_TOC  = 2'd2
    } cause_e;

    typedef struct packed {
        logic             clr_en;
        logic [MAX_W-1:0] clr_mask;
    } clr_req_t;
endpackage

// File: rtl/eir_set_decode.sv
module eir_set_decode #(
    parameter int REG_W     = 64,
    parameter int NARROW_W  = 32,
    parameter int DATA_W    = 32,
    parameter bit WIDE_CORE = 1'b1
) (
    input  logic              wide_dflt,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timer,
    output logic [REG_W-1:0]  set_vec
);
    localparam int IDX_W = $clog2(REG_W);

    logic             wide_eff;
    logic [IDX_W-1:0] lim;
    logic [IDX_W-1:0] idx;

    always_comb begin
        wide_eff = WIDE_CORE && wide_dflt;
        lim      = wide_eff ? IDX_W'(REG_W - 1) : IDX_W'(NARROW_W - 1);
        idx      = ~wdata[IDX_W-1:0] & lim;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        assign set_vec[i] = (wr_ok && (idx == IDX_W'(i))) ||
                            (timer && (lim == IDX_W'(i)));
    end
endmodule

// File: rtl/eir_pending_reg.sv
module eir_pending_reg
    import ext_irq_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  clr_req_t         clr,
    output logic [REG_W-1:0] pend_q
);
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        clr_vec = clr.clr_en ? clr.clr_mask[REG_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/eir_take_arb.sv
module eir_take_arb
    import ext_irq_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_set,
    input  logic             take_ack,
    input  logic             psw_i,
    input  logic [REG_W-1:0] pend,
    input  logic [REG_W-1:0] mask,
    output cause_e           cause
);
    logic nmi_q;

    always_comb begin
        if (nmi_q)                             cause = CAUSE_TOC;
        else if (psw_i && |(pend & mask))      cause = CAUSE_EXT;
        else                                   cause = CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) nmi_q <= 1'b0;
        else     nmi_q <= nmi_set | (nmi_q & ~(take_ack && cause == CAUSE_TOC));
    end
endmodule

// File: rtl/ext_irq_pending.sv
module ext_irq_pending
    import ext_irq_pkg::*;
#(
    parameter int REG_W     = 64,
    parameter int NARROW_W  = 32,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int ACC_BYTES = 4,
    parameter bit WIDE_CORE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_dflt,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              timer_alarm,
    input  logic              clr_en,
    input  logic [REG_W-1:0]  clr_mask,
    input  logic              mask_wr_en,
    input  logic [REG_W-1:0]  mask_wdata,
    input  logic              psw_i,
    input  logic              nmi_set,
    input  logic              take_ack,
    output logic              irq_line,
    output logic [1:0]        take_cause
);
    logic             size_ok;
    logic             wr_ok;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] pend_q;
    logic [REG_W-1:0] mask_q;
    clr_req_t         clr;
    cause_e           cause;

    always_comb begin
        size_ok = (bus_size == SIZE_W'(ACC_BYTES));
        wr_ok   = bus_wr_en && size_ok;
        clr     = '0;
        clr.clr_en = clr_en;
        clr.clr_mask[REG_W-1:0] = clr_mask;
    end

    eir_set_decode #(
        .REG_W(REG_W), .NARROW_W(NARROW_W), .DATA_W(DATA_W), .WIDE_CORE(WIDE_CORE)
    ) u_dec (
        .wide_dflt(wide_dflt), .wr_ok(wr_ok), .wdata(bus_wdata),
        .timer(timer_alarm), .set_vec(set_vec)
    );

    eir_pending_reg #(.REG_W(REG_W)) u_pend (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr(clr), .pend_q(pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst)             mask_q <= '0;
        else if (mask_wr_en) mask_q <= mask_wdata;
    end

    eir_take_arb #(.REG_W(REG_W)) u_arb (
        .clk(clk), .rst(rst), .nmi_set(nmi_set), .take_ack(take_ack),
        .psw_i(psw_i), .pend(pend_q), .mask(mask_q), .cause(cause)
    );

    assign bus_rdata  = (bus_rd_en && size_ok) ? pend_q : '0;
    assign irq_line   = |pend_q;
    assign take_cause = cause;
endmodule

// File: rtl/ext_irq_pending_chk.sv
module ext_irq_pending_chk #(
    parameter int REG_W     = 64,
    parameter int SIZE_W    = 4,
    parameter int ACC_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic [SIZE_W-1:0] bus_size,
    input logic              timer_alarm,
    input logic              clr_en,
    input logic [REG_W-1:0]  clr_mask,
    input logic [REG_W-1:0]  set_vec,
    input logic [REG_W-1:0]  pend_q,
    input logic [REG_W-1:0]  mask_q,
    input logic              psw_i,
    input logic              nmi_set,
    input logic [1:0]        take_cause
);
    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R6
    clear_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && set_vec == '0) |=> ((pend_q & $past(clr_mask)) == '0));

    // R4
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_size != SIZE_W'(ACC_BYTES) && !timer_alarm && !clr_en)
        |=> $stable(pend_q));

    // R9
    ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (take_cause == 2'd1) |-> (psw_i && ((pend_q & mask_q) != '0)));

    // R10
    nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_set |=> (take_cause == 2'd2));
endmodule

bind ext_irq_pending ext_irq_pending_chk #(
    .REG_W(REG_W), .SIZE_W(SIZE_W), .ACC_BYTES(ACC_BYTES)
) u_chk (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_size(bus_size),
    .timer_alarm(timer_alarm), .clr_en(clr_en), .clr_mask(clr_mask),
    .set_vec(set_vec), .pend_q(pend_q), .mask_q(mask_q), .psw_i(psw_i),
    .nmi_set(nmi_set), .take_cause(take_cause)
);

// File: tb/test_ext_irq_pending.sv
module test_ext_irq_pending;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wide_dflt, bus_wr_en, bus_rd_en, timer_alarm, clr_en;
    logic        mask_wr_en, psw_i, nmi_set, take_ack;
    logic [3:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [63:0] clr_mask, mask_wdata, bus_rdata;
    logic        irq_line;
    logic [1:0]  take_cause;

    int tests = 0;
    int fails = 0;
    logic [63:0] m_pend, m_mask;
    logic        m_nmi;

    ext_irq_pending i_ext_irq_pending (
        .clk(clk), .rst(rst), .wide_dflt(wide_dflt), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .timer_alarm(timer_alarm), .clr_en(clr_en),
        .clr_mask(clr_mask), .mask_wr_en(mask_wr_en), .mask_wdata(mask_wdata),
        .psw_i(psw_i), .nmi_set(nmi_set), .take_ack(take_ack),
        .irq_line(irq_line), .take_cause(take_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] bit_of(input logic [31:0] d, input logic wide);
        int lim;
        lim = wide ? 63 : 31;
        return 64'd1 << (int'(~d[5:0]) & lim);
    endfunction

    function automatic logic [1:0] exp_cause();
        if (m_nmi) return 2'd2;
        if (psw_i && (m_pend & m_mask) != 0) return 2'd1;
        return 2'd0;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wide_dflt = wide_dflt; bus_wr_en = 0; bus_rd_en = 0; bus_size = 4'd4;
        bus_wdata = 0; timer_alarm = 0; clr_en = 0; clr_mask = 0;
        mask_wr_en = 0; mask_wdata = 0; nmi_set = 0; take_ack = 0;
    endtask

    // Check outputs, clock once, update the model.
    task automatic cycle();
        logic [63:0] er, sv, cv;
        logic [1:0]  ec;
        #1;
        er = (bus_rd_en && bus_size == 4) ? m_pend : 64'd0;
        ec = exp_cause();
        chk(bus_rdata == er, "R5/R4 read", bus_rdata, er);
        chk(take_cause == ec, "R9/R10 cause", 64'(take_cause), 64'(ec));
        chk(irq_line == (m_pend != 0), "R8 line", 64'(irq_line), 64'(m_pend != 0));
        @(posedge clk);
        sv = 0;
        if (bus_wr_en && bus_size == 4) sv |= bit_of(bus_wdata, wide_dflt);
        if (timer_alarm) sv |= bit_of(32'd0, wide_dflt);
        cv = clr_en ? clr_mask : 64'd0;
        m_pend = (m_pend & ~cv) | sv;
        if (mask_wr_en) m_mask = mask_wdata;
        m_nmi = nmi_set | (m_nmi & ~(take_ack && ec == 2'd2));
        @(negedge clk);
    endtask

    task automatic post(input logic [31:0] d, input logic [3:0] sz);
        idle(); bus_wr_en = 1; bus_wdata = d; bus_size = sz; cycle(); idle();
    endtask

    task automatic read_chk(input string tag, input logic [63:0] exp);
        idle(); bus_rd_en = 1; #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        cycle(); idle();
    endtask

    task automatic clear_all();
        idle(); clr_en = 1; clr_mask = '1; cycle(); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        wide_dflt = 1; psw_i = 0; idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        m_pend = 0; m_mask = 0; m_nmi = 0;
        // R1 reset state
        bus_rd_en = 1; #1;
        chk(bus_rdata == 0, "R1 pending", bus_rdata, 0);
        chk(take_cause == 0, "R1 cause", 64'(take_cause), 0);
        chk(irq_line == 0, "R1 line", 64'(irq_line), 0);
        idle();

        // R2 wide mapping
        wide_dflt = 1;
        post(32'd0, 4);  read_chk("R2 wide data0->bit63", 64'h8000_0000_0000_0000);
        post(32'd63, 4); read_chk("R2 wide data63->bit0", 64'h8000_0000_0000_0001);
        clear_all();
        // R3 narrow mapping
        wide_dflt = 0;
        post(32'd0, 4);  read_chk("R3 narrow data0->bit31", 64'h8000_0000);
        post(32'd32, 4); read_chk("R3 narrow data32->bit31", 64'h8000_0000);
        post(32'd31, 4); read_chk("R3 narrow data31->bit0", 64'h8000_0001);
        // R4 bad size
        post(32'd1, 2); post(32'd1, 8);
        read_chk("R4 bad size write ignored", 64'h8000_0001);
        idle(); bus_rd_en = 1; bus_size = 2; #1;
        chk(bus_rdata == 0, "R4 bad size read", bus_rdata, 0);
        cycle(); idle();
        // R6 clear
        idle(); clr_en = 1; clr_mask = 64'h1; cycle(); idle();
        read_chk("R6 w1c", 64'h8000_0000);
        // R7 set wins
        idle(); bus_wr_en = 1; bus_wdata = 32'd30; clr_en = 1; clr_mask = 64'h2; cycle(); idle();
        read_chk("R7 set wins", 64'h8000_0002);
        clear_all();
        // R11 timer
        idle(); timer_alarm = 1; cycle(); idle();
        read_chk("R11 timer narrow", 64'h8000_0000);
        wide_dflt = 1;
        idle(); timer_alarm = 1; cycle(); idle();
        read_chk("R11 timer wide", 64'h8000_0000_8000_0000);
        // R9 mask gating
        psw_i = 1; idle(); #1;
        chk(take_cause == 0, "R9 mask zero", 64'(take_cause), 0);
        idle(); mask_wr_en = 1; mask_wdata = 64'h8000_0000_0000_0000; cycle(); idle(); #1;
        chk(take_cause == 1, "R9 ext taken", 64'(take_cause), 1);
        idle(); take_ack = 1; cycle(); idle();
        read_chk("R9 ack keeps pending", 64'h8000_0000_8000_0000);
        psw_i = 0; #1;
        chk(take_cause == 0, "R9 psw_i off", 64'(take_cause), 0);
        // R10 nmi priority
        psw_i = 1; idle(); nmi_set = 1; cycle(); idle(); #1;
        chk(take_cause == 2, "R10 toc over ext", 64'(take_cause), 2);
        idle(); take_ack = 1; nmi_set = 1; cycle(); idle(); #1;
        chk(take_cause == 2, "R10 set wins over ack", 64'(take_cause), 2);
        idle(); take_ack = 1; cycle(); idle(); #1;
        chk(take_cause == 1, "R10 ack clears toc", 64'(take_cause), 1);
        clear_all();

        // Random mix, checked every cycle against the model
        for (int n = 0; n < 3000; n++) begin
            idle();
            wide_dflt   = ($urandom % 8) != 0;
            psw_i       = $urandom % 2;
            bus_wr_en   = ($urandom % 3) == 0;
            bus_rd_en   = $urandom % 2;
            bus_size    = (($urandom % 5) == 0) ? 4'($urandom % 9) : 4'd4;
            bus_wdata   = $urandom;
            timer_alarm = ($urandom % 16) == 0;
            clr_en      = ($urandom % 4) == 0;
            clr_mask    = {$urandom, $urandom};
            mask_wr_en  = ($urandom % 8) == 0;
            mask_wdata  = {$urandom, $urandom};
            nmi_set     = ($urandom % 32) == 0;
            take_ack    = ($urandom % 4) == 0;
            cycle();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule